// File: doc/BRIEF.md
# Index Prefix Operand Substitution Decoder

This block sits beside the instruction decoder of an 8-bit accumulator-style CPU core. Once a core has fetched one of the two index prefix bytes, the block looks at the opcode that follows and works out which operands the execution stage should use. The prefix byte picks either the first index register (X) or the second index register (Y). For each opcode the block reports one of four outcomes:

- the H, L or HL operands are replaced by index-register parts;
- the opcode becomes a displacement memory access based on the index register;
- the opcode goes to the bit-operation page;
- the prefix has no effect.

The decode logic is purely combinational. Its result is captured in an output register on every cycle in which `dec_en` is high, so the result appears one clock later and stays in place until the next decode. The memory cycles and the bit-page operations are carried out elsewhere. When the prefix does not apply, the block raises `nop_hold`. The sequencer then treats the prefix as a 4-T no-operation, decodes the next byte without the prefix, and blocks interrupts between the two.

Top module: `idx_pfx_top`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs are set as follows. `out_vld`, `undoc`, `disp_mem`, `cb_page` and `nop_hold` become 0. `dst_sel` and `src_sel` become 15 (none). `rp_dst` and `rp_src` become 7 (none). `alu_op` becomes 15 (no operation).
- R2: An opcode presented with `dec_en` high at a clock edge produces its decoded outputs, with `out_vld` high, right after that edge.
- R3: An 8-bit form that has no memory operand and uses H or L is flagged with `undoc`=1, and each H or L operand is replaced by an index half. These forms are: register-to-register load, immediate load, INC, DEC, and the eight accumulator operations. The 8-bit operand codes are:
  - 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory, 7 A;
  - 8 X-high, 9 X-low, 10 Y-high, 11 Y-low;
  - 12 immediate, 15 none.
- R4: When both operands of a register load are H or L, both become index halves. For example, opcode 0x65 with X selected gives destination 8 and source 9.
- R5: Opcodes with a memory operand (code 6) become displacement forms, with `disp_mem`=1 and `undoc`=0. A register operand H or L in these forms keeps its real code (4 or 5).
- R6: The 16-bit forms use the whole index register and set both 8-bit selects to 15. The operations that set `alu_op` are 11 (16-bit add), 12 (16-bit increment) and 13 (16-bit decrement). The 16-bit pair codes are 0 BC, 1 DE, 2 HL, 3 SP, 4 X, 5 Y and 7 none. The forms are:

  | Form | Opcodes |
  |------|---------|
  | jump through the pair | 0xE9 |
  | stack-pointer load | 0xF9 |
  | increment / decrement | 0x23, 0x2B |
  | 16-bit add | 0x09, 0x19, 0x29, 0x39 |
  | push / pop | 0xE5, 0xE1 |
  | immediate load | 0x21 |
  | absolute store / load | 0x22, 0x2A |
  | exchange with stack top | 0xE3 |

- R7: In the 16-bit add, the pair field (opcode bits 5:4) selects the second operand: 0 gives BC, 1 gives DE, 3 gives SP, and 2 names the selected index register itself.
- R8: Any opcode the prefix does not affect gives `nop_hold`=1 with both 8-bit selects at 15, both pair selects at 7, `alu_op`=15, `undoc`=0 and `disp_mem`=0. This includes 0x76 and every load, ALU or INC/DEC form that uses neither H, L nor memory.
- R9: `sel_iy`=1 selects Y: the halves are 10 and 11 and the pair is 5. `sel_iy`=0 selects X: the halves are 8 and 9 and the pair is 4.
- R10: Opcode 0xCB gives `cb_page`=1, `disp_mem`=1, both 8-bit selects at 6 (memory), and `nop_hold`=0.
- R11: In a cycle that follows an edge where `dec_en` was low, `out_vld` is 0 and every decoded field keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_en | input | 1 | Decode strobe for `opcode` |
| sel_iy | input | 1 | 1 selects index register Y, 0 selects X |
| opcode | input | 8 | Opcode byte following the prefix |
| out_vld | output | 1 | Decoded fields were updated on the last edge |
| dst_sel | output | 4 | 8-bit destination operand code |
| src_sel | output | 4 | 8-bit source operand code |
| rp_dst | output | 3 | 16-bit destination pair code |
| rp_src | output | 3 | 16-bit source pair code |
| alu_op | output | 4 | Operation code (0-7 accumulator operations, 8 INC, 9 DEC, 10 move, 11-13 16-bit, 15 none) |
| disp_mem | output | 1 | Displacement memory form |
| undoc | output | 1 | Undocumented index-half form |
| cb_page | output | 1 | Opcode enters the bit-operation page |
| nop_hold | output | 1 | Prefix acts as a NOP; the next opcode runs unprefixed with interrupts held off |

## Verification
Several rules are checked by the assertions on every clock:

- `undoc` and `disp_mem` are never both high;
- a NOP outcome carries no operands;
- a 16-bit outcome leaves the 8-bit selects at none;
- the bit-page flag comes with a memory form;
- any Y code appears only after `sel_iy` was high;
- the result registers follow `dec_en` one edge later.

The rest can only be shown by the bench's scenarios. This covers the exact substituted code for each opcode and the rule that displacement forms keep the real H and L. It also covers the pair chosen in the 16-bit add, and the complete split of all 256 opcodes under both index selects into the NOP and the affected classes.

// File: rtl/idx_pfx_pkg.sv
package idx_pfx_pkg;
  localparam int OPC_W = 8;
  localparam int SEL_W = 4;
  localparam int RP_W  = 3;
  localparam int ALU_W = 4;
  localparam int RC_W  = 3;
  localparam int FLD_W = OPC_W - 2 * RC_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_B = 4'd0, SEL_C = 4'd1, SEL_D = 4'd2, SEL_E = 4'd3,
    SEL_H = 4'd4, SEL_L = 4'd5, SEL_MEM = 4'd6, SEL_A = 4'd7,
    SEL_XH = 4'd8, SEL_XL = 4'd9, SEL_YH = 4'd10, SEL_YL = 4'd11,
    SEL_IMM = 4'd12, SEL_NONE = 4'd15
  } opnd_e;

  typedef enum logic [RP_W-1:0] {
    RP_BC = 3'd0, RP_DE = 3'd1, RP_HL = 3'd2, RP_SP = 3'd3,
    RP_IX = 3'd4, RP_IY = 3'd5, RP_NONE = 3'd7
  } pair_e;

  typedef enum logic [ALU_W-1:0] {
    AL_ADD = 4'd0, AL_ADC = 4'd1, AL_SUB = 4'd2, AL_SBC = 4'd3,
    AL_AND = 4'd4, AL_XOR = 4'd5, AL_OR = 4'd6, AL_CP = 4'd7,
    AL_INC = 4'd8, AL_DEC = 4'd9, AL_MOV = 4'd10, AL_ADDW = 4'd11,
    AL_INCW = 4'd12, AL_DECW = 4'd13, AL_NOP = 4'd15
  } alu_e;

  typedef enum logic [2:0] {
    CL_NOP, CL_CB, CL_WIDE, CL_LDRR, CL_ACC, CL_UNI
  } cls_e;

  typedef struct packed {
    opnd_e dst;
    opnd_e src;
    pair_e rpd;
    pair_e rps;
    alu_e  alu;
    logic  mem;
    logic  undoc;
    logic  cb;
    logic  nop;
  } dec_s;

  localparam dec_s DEC_IDLE = '{dst: SEL_NONE, src: SEL_NONE, rpd: RP_NONE,
                                rps: RP_NONE, alu: AL_NOP, mem: 1'b0,
                                undoc: 1'b0, cb: 1'b0, nop: 1'b0};
endpackage

// File: rtl/idx_half_map.sv
module idx_half_map
  import idx_pfx_pkg::*;
(
  input  logic [RC_W-1:0] code,
  input  logic            sub,
  input  logic            iy,
  output opnd_e           opnd
);
  localparam logic [RC_W-1:0] CODE_HI = RC_W'(4);
  localparam logic [RC_W-1:0] CODE_LO = RC_W'(5);

  always_comb begin
    opnd = opnd_e'(SEL_W'(code));
    if (sub && code == CODE_HI)      opnd = iy ? SEL_YH : SEL_XH;
    else if (sub && code == CODE_LO) opnd = iy ? SEL_YL : SEL_XL;
  end
endmodule

// File: rtl/idx_pfx_decode.sv
module idx_pfx_decode
  import idx_pfx_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic             iy,
  output dec_s             dec
);
  logic [FLD_W-1:0] x;
  logic [RC_W-1:0]  y, z, dcode, scode;
  logic             y_hl, z_hl, y_m, z_m, sub, wide;
  cls_e             cls;
  opnd_e            dmap, smap;
  pair_e            ixp;

  assign x    = opc[OPC_W-1 -: FLD_W];
  assign y    = opc[2*RC_W-1 -: RC_W];
  assign z    = opc[RC_W-1:0];
  assign y_hl = (y == 3'd4) || (y == 3'd5);
  assign z_hl = (z == 3'd4) || (z == 3'd5);
  assign y_m  = (y == 3'd6);
  assign z_m  = (z == 3'd6);
  assign ixp  = iy ? RP_IY : RP_IX;

  always_comb begin
    case (opc)
      8'h09, 8'h19, 8'h29, 8'h39, 8'h21, 8'h22, 8'h2A, 8'h23, 8'h2B,
      8'hE1, 8'hE5, 8'hE3, 8'hE9, 8'hF9: wide = 1'b1;
      default:                           wide = 1'b0;
    endcase
  end

  always_comb begin
    cls   = CL_NOP;
    dcode = y;
    scode = z;
    sub   = 1'b0;
    if (opc == 8'hCB) begin
      cls = CL_CB;
    end else if (wide) begin
      cls = CL_WIDE;
    end else if (x == 2'd1 && opc != 8'h76) begin
      if (y_m || z_m || y_hl || z_hl) cls = CL_LDRR;
      sub = !(y_m || z_m);
    end else if (x == 2'd2) begin
      if (z_m || z_hl) cls = CL_ACC;
      dcode = 3'd7;
      sub   = !z_m;
    end else if (x == 2'd0 && z >= 3'd4 && z <= 3'd6) begin
      if (y_m || y_hl) cls = CL_UNI;
      scode = y;
      sub   = !y_m;
    end
  end

  idx_half_map u_dmap (.code(dcode), .sub(sub), .iy(iy), .opnd(dmap));
  idx_half_map u_smap (.code(scode), .sub(sub), .iy(iy), .opnd(smap));

  always_comb begin
    dec = DEC_IDLE;
    unique case (cls)
      CL_CB: begin
        dec.dst = SEL_MEM;
        dec.src = SEL_MEM;
        dec.mem = 1'b1;
        dec.cb  = 1'b1;
      end
      CL_WIDE: begin
        dec.alu = AL_MOV;
        case (opc)
          8'h09, 8'h19, 8'h29, 8'h39: begin
            dec.alu = AL_ADDW;
            dec.rpd = ixp;
            dec.rps = (opc[5:4] == 2'd2) ? ixp : pair_e'({1'b0, opc[5:4]});
          end
          8'h21, 8'h2A, 8'hE1: dec.rpd = ixp;
          8'h22, 8'hE5, 8'hE9: dec.rps = ixp;
          8'h23: begin dec.rpd = ixp; dec.rps = ixp; dec.alu = AL_INCW; end
          8'h2B: begin dec.rpd = ixp; dec.rps = ixp; dec.alu = AL_DECW; end
          8'hE3: begin dec.rpd = ixp; dec.rps = ixp; end
          8'hF9: begin dec.rpd = RP_SP; dec.rps = ixp; end
          default: dec.alu = AL_NOP;
        endcase
      end
      CL_LDRR, CL_ACC, CL_UNI: begin
        dec.dst   = dmap;
        dec.src   = smap;
        dec.mem   = !sub;
        dec.undoc = sub;
        if (cls == CL_LDRR)     dec.alu = AL_MOV;
        else if (cls == CL_ACC) dec.alu = alu_e'({1'b0, y});
        else begin
          case (z)
            3'd4:    dec.alu = AL_INC;
            3'd5:    dec.alu = AL_DEC;
            default: begin dec.alu = AL_MOV; dec.src = SEL_IMM; end
          endcase
        end
      end
      default: dec.nop = 1'b1;
    endcase
  end
endmodule

// File: rtl/idx_pfx_top.sv
module idx_pfx_top
  import idx_pfx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_en,
  input  logic             sel_iy,
  input  logic [OPC_W-1:0] opcode,
  output logic             out_vld,
  output logic [SEL_W-1:0] dst_sel,
  output logic [SEL_W-1:0] src_sel,
  output logic [RP_W-1:0]  rp_dst,
  output logic [RP_W-1:0]  rp_src,
  output logic [ALU_W-1:0] alu_op,
  output logic             disp_mem,
  output logic             undoc,
  output logic             cb_page,
  output logic             nop_hold
);
  dec_s dec_d, dec_q;
  logic vld_q;

  idx_pfx_decode u_dec (.opc(opcode), .iy(sel_iy), .dec(dec_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q <= DEC_IDLE;
      vld_q <= 1'b0;
    end else begin
      vld_q <= dec_en;
      if (dec_en) dec_q <= dec_d;
    end
  end

  assign out_vld  = vld_q;
  assign dst_sel  = dec_q.dst;
  assign src_sel  = dec_q.src;
  assign rp_dst   = dec_q.rpd;
  assign rp_src   = dec_q.rps;
  assign alu_op   = dec_q.alu;
  assign disp_mem = dec_q.mem;
  assign undoc    = dec_q.undoc;
  assign cb_page  = dec_q.cb;
  assign nop_hold = dec_q.nop;
endmodule

// File: rtl/idx_pfx_chk.sv
module idx_pfx_chk
  import idx_pfx_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             dec_en,
  input logic             sel_iy,
  input logic [OPC_W-1:0] opcode,
  input logic             out_vld,
  input logic [SEL_W-1:0] dst_sel,
  input logic [SEL_W-1:0] src_sel,
  input logic [RP_W-1:0]  rp_dst,
  input logic [RP_W-1:0]  rp_src,
  input logic [ALU_W-1:0] alu_op,
  input logic             disp_mem,
  input logic             undoc,
  input logic             cb_page,
  input logic             nop_hold
);
  logic d_half, s_half, y_used;
  assign d_half = (dst_sel >= 4'd8) && (dst_sel <= 4'd11);
  assign s_half = (src_sel >= 4'd8) && (src_sel <= 4'd11);
  assign y_used = (dst_sel == 4'd10) || (dst_sel == 4'd11) || (src_sel == 4'd10) ||
                  (src_sel == 4'd11) || (rp_dst == 3'd5) || (rp_src == 3'd5);

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    dec_en |=> out_vld);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_en |=> (!out_vld && $stable(dst_sel) && $stable(src_sel) &&
                 $stable(alu_op) && $stable(undoc) && $stable(nop_hold)));

  // R8
  nop_clean_chk: assert property (@(posedge clk) disable iff (rst)
    nop_hold |-> (!undoc && !disp_mem && dst_sel == 4'd15 && src_sel == 4'd15 &&
                  rp_dst == 3'd7 && rp_src == 3'd7));

  // R5
  mem_doc_chk: assert property (@(posedge clk) disable iff (rst)
    disp_mem |-> !undoc);

  // R3
  undoc_half_chk: assert property (@(posedge clk) disable iff (rst)
    undoc |-> (d_half || s_half));

  // R6
  wide_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (rp_dst != 3'd7 || rp_src != 3'd7) |-> (dst_sel == 4'd15 && src_sel == 4'd15 && !undoc));

  // R9
  iy_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && y_used) |-> $past(sel_iy));

  // R10
  cb_mem_chk: assert property (@(posedge clk) disable iff (rst)
    cb_page |-> (disp_mem && !nop_hold));
endmodule

bind idx_pfx_top idx_pfx_chk u_chk (.*);

// File: tb/tb_idx_pfx_top.sv
`timescale 1ns/1ps
module tb_idx_pfx_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_en = 1'b0;
  logic       sel_iy = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic       out_vld, disp_mem, undoc, cb_page, nop_hold;
  logic [3:0] dst_sel, src_sel, alu_op;
  logic [2:0] rp_dst, rp_src;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit armed  = 1'b0;

  logic [3:0] e_d, e_s, e_alu;
  logic [2:0] e_rd, e_rs;
  logic       e_m, e_u, e_cb, e_n, e_v, e_rst;
  string      e_tag;

  always #2 clk = ~clk;

  idx_pfx_top dut (.*);

  function automatic logic [3:0] half(input logic [2:0] v, input logic iy);
    if (v == 3'd4) return iy ? 4'd10 : 4'd8;
    if (v == 3'd5) return iy ? 4'd11 : 4'd9;
    return {1'b0, v};
  endfunction

  task automatic model_reset();
    e_d = 4'd15; e_s = 4'd15; e_rd = 3'd7; e_rs = 3'd7; e_alu = 4'd15;
    e_m = 1'b0; e_u = 1'b0; e_cb = 1'b0; e_n = 1'b0;
  endtask

  task automatic model(input logic [7:0] op, input logic iy);
    logic [1:0] x; logic [2:0] y, z, ip; logic [1:0] pf;
    x = op[7:6]; y = op[5:3]; z = op[2:0]; pf = op[5:4];
    ip = iy ? 3'd5 : 3'd4;
    model_reset();
    e_tag = "R8";
    if (op == 8'hCB) begin
      e_d = 4'd6; e_s = 4'd6; e_m = 1'b1; e_cb = 1'b1; e_tag = "R10";
    end else if (op == 8'h09 || op == 8'h19 || op == 8'h29 || op == 8'h39) begin
      e_rd = ip; e_rs = (pf == 2'd2) ? ip : {1'b0, pf}; e_alu = 4'd11; e_tag = "R7";
    end else if (op == 8'h21 || op == 8'h2A || op == 8'hE1) begin
      e_rd = ip; e_alu = 4'd10; e_tag = "R6";
    end else if (op == 8'h22 || op == 8'hE5 || op == 8'hE9) begin
      e_rs = ip; e_alu = 4'd10; e_tag = "R6";
    end else if (op == 8'h23 || op == 8'h2B || op == 8'hE3) begin
      e_rd = ip; e_rs = ip; e_tag = "R6";
      e_alu = (op == 8'h23) ? 4'd12 : (op == 8'h2B) ? 4'd13 : 4'd10;
    end else if (op == 8'hF9) begin
      e_rd = 3'd3; e_rs = ip; e_alu = 4'd10; e_tag = "R6";
    end else if (x == 2'd1 && op != 8'h76) begin
      if (y == 3'd6 || z == 3'd6) begin
        e_d = {1'b0, y}; e_s = {1'b0, z}; e_m = 1'b1; e_alu = 4'd10; e_tag = "R5";
      end else if (y == 3'd4 || y == 3'd5 || z == 3'd4 || z == 3'd5) begin
        e_d = half(y, iy); e_s = half(z, iy); e_u = 1'b1; e_alu = 4'd10;
        e_tag = ((y == 3'd4 || y == 3'd5) && (z == 3'd4 || z == 3'd5)) ? "R4" : "R3";
      end else e_n = 1'b1;
    end else if (x == 2'd2) begin
      if (z == 3'd6) begin
        e_d = 4'd7; e_s = 4'd6; e_m = 1'b1; e_alu = {1'b0, y}; e_tag = "R5";
      end else if (z == 3'd4 || z == 3'd5) begin
        e_d = 4'd7; e_s = half(z, iy); e_u = 1'b1; e_alu = {1'b0, y}; e_tag = "R3";
      end else e_n = 1'b1;
    end else if (x == 2'd0 && z >= 3'd4 && z <= 3'd6 && (y >= 3'd4 && y <= 3'd6)) begin
      e_alu = (z == 3'd4) ? 4'd8 : (z == 3'd5) ? 4'd9 : 4'd10;
      if (y == 3'd6) begin
        e_d = 4'd6; e_s = (z == 3'd6) ? 4'd12 : 4'd6; e_m = 1'b1; e_tag = "R5";
      end else begin
        e_d = half(y, iy); e_s = (z == 3'd6) ? 4'd12 : half(y, iy); e_u = 1'b1; e_tag = "R3";
      end
    end else e_n = 1'b1;
    if (e_n) e_tag = "R8";
  endtask

  // reference update on each edge
  always @(posedge clk) begin
    e_rst = rst;
    if (rst) begin
      model_reset(); e_v = 1'b0;
    end else begin
      e_v = dec_en;
      if (dec_en) model(opcode, sel_iy);
    end
    armed = 1'b1;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      string tag;
      tag = e_rst ? "R1" : (e_v ? e_tag : "R11");
      checks++;
      if (out_vld !== e_v || dst_sel !== e_d || src_sel !== e_s || rp_dst !== e_rd ||
          rp_src !== e_rs || alu_op !== e_alu || disp_mem !== e_m || undoc !== e_u ||
          cb_page !== e_cb || nop_hold !== e_n) begin
        fails++;
        $display("FAIL %s op=%h iy=%0d act v%0d d%0d s%0d rd%0d rs%0d a%0d m%0d u%0d cb%0d n%0d exp v%0d d%0d s%0d rd%0d rs%0d a%0d m%0d u%0d cb%0d n%0d",
                 tag, opcode, sel_iy, out_vld, dst_sel, src_sel, rp_dst, rp_src, alu_op,
                 disp_mem, undoc, cb_page, nop_hold, e_v, e_d, e_s, e_rd, e_rs, e_alu,
                 e_m, e_u, e_cb, e_n);
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic iy);
    @(negedge clk);
    opcode = op; sel_iy = iy; dec_en = 1'b1;
    @(negedge clk);
    dec_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_vld == 1'b0 && nop_hold == 1'b0 && undoc == 1'b0, "R1", "flags", int'(out_vld), 0);
    chk(dst_sel == 4'd15 && rp_src == 3'd7, "R1", "selects", int'(dst_sel), 15);
    rst = 1'b0;

    // R4, R3: both halves
    drive(8'h65, 1'b0);
    chk(dst_sel == 4'd8 && src_sel == 4'd9 && undoc, "R4", "LD XH->XL dst", int'(dst_sel), 8);
    @(negedge clk);
    // R11 hold on idle
    chk(!out_vld && dst_sel == 4'd8 && src_sel == 4'd9, "R11", "hold dst", int'(dst_sel), 8);
    // R9 Y halves
    drive(8'h7C, 1'b1);
    chk(dst_sel == 4'd7 && src_sel == 4'd10 && undoc, "R9", "LD A,YH src", int'(src_sel), 10);
    // R5 displacement keeps real H/L
    drive(8'h66, 1'b0);
    chk(dst_sel == 4'd4 && src_sel == 4'd6 && disp_mem && !undoc, "R5", "LD H,(X+d) dst", int'(dst_sel), 4);
    drive(8'h74, 1'b1);
    chk(dst_sel == 4'd6 && src_sel == 4'd4 && disp_mem, "R5", "LD (Y+d),H src", int'(src_sel), 4);
    drive(8'h35, 1'b0);
    chk(alu_op == 4'd9 && dst_sel == 4'd6 && disp_mem, "R5", "DEC (X+d) alu", int'(alu_op), 9);
    // R3 immediate and accumulator forms
    drive(8'h26, 1'b0);
    chk(dst_sel == 4'd8 && src_sel == 4'd12 && undoc, "R3", "LD XH,n src", int'(src_sel), 12);
    drive(8'hBD, 1'b1);
    chk(alu_op == 4'd7 && src_sel == 4'd11 && undoc, "R3", "CP YL src", int'(src_sel), 11);
    // R7 add with itself, R6 other 16-bit forms
    drive(8'h29, 1'b1);
    chk(rp_dst == 3'd5 && rp_src == 3'd5 && alu_op == 4'd11, "R7", "ADD Y,Y src", int'(rp_src), 5);
    drive(8'h39, 1'b0);
    chk(rp_dst == 3'd4 && rp_src == 3'd3, "R7", "ADD X,SP src", int'(rp_src), 3);
    drive(8'hE9, 1'b0);
    chk(rp_src == 3'd4 && rp_dst == 3'd7 && dst_sel == 4'd15, "R6", "JP (X) src", int'(rp_src), 4);
    drive(8'hF9, 1'b1);
    chk(rp_dst == 3'd3 && rp_src == 3'd5, "R6", "LD SP,Y dst", int'(rp_dst), 3);
    // R8 unaffected opcodes
    drive(8'h47, 1'b0);
    chk(nop_hold && dst_sel == 4'd15 && !undoc, "R8", "LD B,A nop", int'(nop_hold), 1);
    drive(8'h76, 1'b1);
    chk(nop_hold && !disp_mem, "R8", "0x76 nop", int'(nop_hold), 1);
    drive(8'h00, 1'b0);
    chk(nop_hold && alu_op == 4'd15, "R8", "0x00 nop", int'(nop_hold), 1);
    // R10
    drive(8'hCB, 1'b1);
    chk(cb_page && disp_mem && !nop_hold, "R10", "CB page", int'(cb_page), 1);

    // R2 back-to-back sweep of every opcode under both selects
    for (int j = 0; j < 2; j++) begin
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        opcode = 8'(i); sel_iy = 1'(j); dec_en = 1'b1;
      end
    end
    @(negedge clk);
    dec_en = 1'b0;

    // mixed strobes
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      opcode = 8'($urandom); sel_iy = 1'($urandom); dec_en = 1'($urandom);
    end
    @(negedge clk);
    dec_en = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule